// File: doc/BRIEF.md
# Paged Program Counter Unit

This block keeps the instruction fetch address for a small 8-bit controller whose 12-bit instruction words sit in a program store divided into 512-word pages. Each instruction cycle it either advances the address by one or loads it from one of three sources. A jump takes a 9-bit target from the instruction. A subroutine call takes an 8-bit target from the instruction. A write to the low program-counter byte takes its value from the ALU result. The page number above bit 8 never comes from the instruction. It comes from a two-bit page preselect value, which this block holds and which software sets through a write strobe.

Calls and computed jumps always clear bit 8, so they reach only the lower half of a page. A sequential step past the end of a page moves into the next page and leaves the preselect bits as they were. The next jump, call or low-byte write therefore returns to the preselected page. The low byte of the counter is always readable. The return address for a call (the counter already advanced past the call) is offered on its own output for an external stack. The parameter `PC_W` selects one of two variants: a 9-bit single-page unit or an 11-bit four-page unit.

Top module: `paged_pc_unit`

## Requirements
- R1: While `rst_n` is low, `fetch_addr` is all ones across `PC_W` bits and `pa_q` is 0.
- R2: When `adv_en` is high and no branch input is high, `fetch_addr` increases by one at the clock edge. When `adv_en` is low, `fetch_addr` and `pa_q` are unchanged except for writes through `pa_we`.
- R3: A sequential step from the all-ones address gives address 0.
- R4: When `br_goto` is high with `adv_en`, the next `fetch_addr[8:0]` equals `imm_field[8:0]`. In the 11-bit variant, bits 10:9 equal `pa_q` as it stood before the edge.
- R5: When `br_call` is high with `adv_en` and `br_goto` is low, the next `fetch_addr[7:0]` equals `imm_field[7:0]` and bit 8 is 0. In the 11-bit variant, bits 10:9 equal `pa_q`.
- R6: When `br_pclw` is high with `adv_en` and the other two branch inputs are low, the next `fetch_addr[7:0]` equals `alu_res`, bit 8 is 0, and bits 10:9 equal `pa_q` in the 11-bit variant.
- R7: A sequential step from 0x1FF gives 0x200 and leaves `pa_q` unchanged. A following jump with `pa_q` = 0 lands in page 0.
- R8: `pcl_rd` always equals `fetch_addr[7:0]`.
- R9: `ret_addr` always equals `fetch_addr + 1`, modulo 2^`PC_W`.
- R10: When more than one branch input is high, `br_goto` wins over `br_call`, which wins over `br_pclw`.
- R11: In the 11-bit variant, `pa_we` high loads `pa_wdata` into `pa_q` at the clock edge, independent of `adv_en`. With `pa_we` low, `pa_q` holds.
- R12: In the 9-bit variant, `pa_q` reads 0 and the `pa_we`/`pa_wdata` inputs have no effect on `fetch_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_en | input | 1 | Instruction-cycle enable |
| br_goto | input | 1 | Jump with 9-bit target |
| br_call | input | 1 | Subroutine call with 8-bit target |
| br_pclw | input | 1 | Instruction writes the low PC byte |
| imm_field | input | 9 | Immediate field of the instruction word |
| alu_res | input | 8 | ALU result for low-byte writes |
| pa_we | input | 1 | Page preselect write strobe |
| pa_wdata | input | 2 | Page preselect write value |
| fetch_addr | output | PC_W | Current program address |
| pcl_rd | output | 8 | Low byte of the program counter |
| ret_addr | output | PC_W | Advanced address for a call's return |
| pa_q | output | 2 | Page preselect bits |

## Verification
The assertions assume that a branch input counts only in a cycle where `adv_en` is high. They also assume that the immediate and ALU buses are stable around the clock edge in the cycles that load them. The stimulus changes inputs only on the falling edge. The randomized section raises at most one branch input per cycle, and the bench counts any cycle where more than one is high. Several branch inputs are raised together only in the directed priority cases. Two instances, one of each width, are driven from the same stimulus so that the page-bit path and its absence are checked side by side.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
   localparam int PAGE_BITS = 9;
   localparam int PCL_BITS  = 8;
   localparam int PSEL_W    = 2;

   typedef enum logic [1:0] {
      SRC_SEQ  = 2'd0,
      SRC_JUMP = 2'd1,
      SRC_SUB  = 2'd2,
      SRC_LOW  = 2'd3
   } pc_src_e;
endpackage

// File: rtl/ppc_src_arb.sv
module ppc_src_arb
   import ppc_pkg::*;
(
   input  logic    adv,
   input  logic    req_jump,
   input  logic    req_sub,
   input  logic    req_low,
   output pc_src_e src
);
   always_comb begin
      src = SRC_SEQ;
      if (adv) begin
         if (req_jump)     src = SRC_JUMP;
         else if (req_sub) src = SRC_SUB;
         else if (req_low) src = SRC_LOW;
      end
   end
endmodule

// File: rtl/ppc_page_reg.sv
module ppc_page_reg
   import ppc_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PSEL_W-1:0] wr_val,
   output logic [PSEL_W-1:0] sel_q
);
   initial begin
      if (SEL_W != 0 && SEL_W != PSEL_W)
         $error("ppc_page_reg: SEL_W must be 0 or %0d", PSEL_W);
   end

   generate
      if (SEL_W > 0) begin : g_paged
         logic [PSEL_W-1:0] sel_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sel_r <= '0;
            else if (wr_en) sel_r <= wr_val;
         end
         assign sel_q = sel_r;

         p_pa_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> $stable(sel_q));
         p_pa_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> (sel_q == $past(wr_val)));
      end else begin : g_flat
         logic sel_unused;
         assign sel_unused = ^{clk, rst_n, wr_en, wr_val};
         assign sel_q = '0;
      end
   endgenerate
endmodule

// File: rtl/ppc_next.sv
module ppc_next
   import ppc_pkg::*;
#(
   parameter int PC_W = 11
) (
   input  logic [PC_W-1:0]     pc_q,
   input  pc_src_e             src,
   input  logic [PAGE_BITS-1:0] imm,
   input  logic [PCL_BITS-1:0] alu,
   input  logic [PSEL_W-1:0]   psel,
   output logic [PC_W-1:0]     pc_nxt,
   output logic [PC_W-1:0]     pc_inc
);
   localparam int HI_W = PC_W - PAGE_BITS;

   logic [PAGE_BITS-1:0] low_tgt;

   assign pc_inc = pc_q + {{(PC_W-1){1'b0}}, 1'b1};

   always_comb begin
      unique case (src)
         SRC_JUMP: low_tgt = imm;
         SRC_SUB:  low_tgt = {1'b0, imm[PCL_BITS-1:0]};
         SRC_LOW:  low_tgt = {1'b0, alu};
         default:  low_tgt = pc_inc[PAGE_BITS-1:0];
      endcase
   end

   generate
      if (HI_W > 0) begin : g_multi
         logic [HI_W-1:0] hi_tgt;
         assign hi_tgt = psel[HI_W-1:0];
         assign pc_nxt = (src == SRC_SEQ) ? pc_inc : {hi_tgt, low_tgt};
      end else begin : g_single
         logic psel_unused;
         assign psel_unused = ^psel;
         assign pc_nxt = (src == SRC_SEQ) ? pc_inc : low_tgt;
      end
   endgenerate
endmodule

// File: rtl/paged_pc_unit.sv
module paged_pc_unit
   import ppc_pkg::*;
#(
   parameter int PC_W = 11
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            adv_en,
   input  logic            br_goto,
   input  logic            br_call,
   input  logic            br_pclw,
   input  logic [8:0]      imm_field,
   input  logic [7:0]      alu_res,
   input  logic            pa_we,
   input  logic [1:0]      pa_wdata,
   output logic [PC_W-1:0] fetch_addr,
   output logic [7:0]      pcl_rd,
   output logic [PC_W-1:0] ret_addr,
   output logic [1:0]      pa_q
);
   localparam int SEL_W = (PC_W > PAGE_BITS) ? PSEL_W : 0;

   initial begin
      if (PC_W != PAGE_BITS && PC_W != PAGE_BITS + PSEL_W)
         $error("paged_pc_unit: PC_W must be %0d or %0d", PAGE_BITS, PAGE_BITS + PSEL_W);
   end

   pc_src_e         src;
   logic [PC_W-1:0] pc_r, pc_nxt, pc_inc;
   logic [1:0]      psel;

   ppc_src_arb u_arb (
      .adv(adv_en), .req_jump(br_goto), .req_sub(br_call), .req_low(br_pclw), .src(src)
   );

   ppc_page_reg #(.SEL_W(SEL_W)) u_page (
      .clk(clk), .rst_n(rst_n), .wr_en(pa_we), .wr_val(pa_wdata), .sel_q(psel)
   );

   ppc_next #(.PC_W(PC_W)) u_next (
      .pc_q(pc_r), .src(src), .imm(imm_field), .alu(alu_res), .psel(psel),
      .pc_nxt(pc_nxt), .pc_inc(pc_inc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pc_r <= '1;
      else if (adv_en) pc_r <= pc_nxt;
   end

   assign fetch_addr = pc_r;
   assign pcl_rd     = pc_r[PCL_BITS-1:0];
   assign ret_addr   = pc_inc;
   assign pa_q       = psel;

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_en |=> $stable(fetch_addr));
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && !br_goto && !br_call && !br_pclw) |=> (fetch_addr == $past(ret_addr)));
   p_jump_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && br_goto) |=> (fetch_addr[8:0] == $past(imm_field)));
   p_sub_bit8_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && !br_goto && (br_call || br_pclw)) |=> (fetch_addr[8] == 1'b0));
   p_low_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && !br_goto && !br_call && br_pclw) |=> (pcl_rd == $past(alu_res)));
endmodule

// File: tb/tb_paged_pc_unit.sv
`timescale 1ns/1ps
module tb_paged_pc_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic adv_en = 1'b0, br_goto = 1'b0, br_call = 1'b0, br_pclw = 1'b0, pa_we = 1'b0;
   logic [8:0] imm_field = '0;
   logic [7:0] alu_res = '0;
   logic [1:0] pa_wdata = '0;
   logic [10:0] fa11, ra11;
   logic [8:0]  fa9, ra9;
   logic [7:0]  pcl11, pcl9;
   logic [1:0]  pa11, pa9;

   int total = 0, bad = 0, multi_hot = 0;
   int m11, m9, mpa;
   bit finished = 0;

   always #4 clk = ~clk;

   paged_pc_unit #(.PC_W(11)) dut (
      .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .br_goto(br_goto), .br_call(br_call),
      .br_pclw(br_pclw), .imm_field(imm_field), .alu_res(alu_res), .pa_we(pa_we),
      .pa_wdata(pa_wdata), .fetch_addr(fa11), .pcl_rd(pcl11), .ret_addr(ra11), .pa_q(pa11));

   paged_pc_unit #(.PC_W(9)) dut9 (
      .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .br_goto(br_goto), .br_call(br_call),
      .br_pclw(br_pclw), .imm_field(imm_field), .alu_res(alu_res), .pa_we(pa_we),
      .pa_wdata(pa_wdata), .fetch_addr(fa9), .pcl_rd(pcl9), .ret_addr(ra9), .pa_q(pa9));

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic int nxt(int pc, int w, int pa, bit a, bit g, bit c, bit p, int imm, int alu);
      int hi = (w == 11) ? (pa << 9) : 0;
      if (!a) return pc;
      if (g)  return hi | (imm & 'h1FF);
      if (c)  return hi | (imm & 'hFF);
      if (p)  return hi | (alu & 'hFF);
      return (pc + 1) & ((1 << w) - 1);
   endfunction

   task automatic check_all(string tag);
      chk({tag, " fetch11"}, fa11, m11);
      chk({tag, " fetch9 R12"}, fa9, m9);
      chk("R8 pcl", pcl11, m11 & 'hFF);
      chk("R9 ret11", ra11, (m11 + 1) & 'h7FF);
      chk("R9 ret9", ra9, (m9 + 1) & 'h1FF);
      chk("R11 pa", pa11, mpa);
      chk("R12 pa9", pa9, 0);
   endtask

   task automatic step(string tag, bit a, bit g, bit c, bit p, int imm, int alu, bit we, int wd);
      adv_en = a; br_goto = g; br_call = c; br_pclw = p;
      imm_field = imm[8:0]; alu_res = alu[7:0]; pa_we = we; pa_wdata = wd[1:0];
      if (int'(g) + int'(c) + int'(p) > 1) multi_hot++;
      m11 = nxt(m11, 11, mpa, a, g, c, p, imm, alu);
      m9  = nxt(m9, 9, 0, a, g, c, p, imm, alu);
      if (we) mpa = wd & 3;
      @(negedge clk);
      check_all(tag);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      adv_en = 0; br_goto = 0; br_call = 0; br_pclw = 0; pa_we = 0;
      m11 = 'h7FF; m9 = 'h1FF; mpa = 0;
      @(negedge clk);
      check_all("R1 reset");
      rst_n = 1'b1;
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      step("R2 seq", 1, 0, 0, 0, 0, 0, 0, 0);
      step("R3 wrap", 1, 0, 0, 0, 0, 0, 0, 0);
      step("R2 hold", 0, 0, 0, 0, 'h123, 'h45, 0, 0);
      step("R2 hold", 0, 1, 0, 0, 'h0AA, 0, 0, 0);
      step("R4 goto", 1, 1, 0, 0, 'h1FE, 0, 0, 0);
      step("R7 seq", 1, 0, 0, 0, 0, 0, 0, 0);
      step("R7 cross", 1, 0, 0, 0, 0, 0, 0, 0);
      step("R7 back", 1, 1, 0, 0, 'h055, 0, 0, 0);
      step("R11 pa write idle", 0, 0, 0, 0, 0, 0, 1, 3);
      step("R4 goto paged", 1, 1, 0, 0, 'h1AB, 0, 0, 0);
      step("R5 call", 1, 0, 1, 0, 'h1CD, 0, 1, 2);
      step("R6 pclw", 1, 0, 0, 1, 'h1FF, 'hF0, 0, 0);
      step("R11 pa write", 1, 0, 0, 0, 0, 0, 1, 3);
      step("R4 goto top", 1, 1, 0, 0, 'h1FF, 0, 0, 0);
      step("R3 wrap", 1, 0, 0, 0, 0, 0, 0, 0);
      step("R10 all", 1, 1, 1, 1, 'h133, 'h77, 0, 0);
      step("R10 call over pclw", 1, 0, 1, 1, 'h1EE, 'h22, 0, 0);
      step("R12 pa ignored", 1, 0, 1, 0, 'h011, 0, 1, 1);
      do_reset();
      for (int i = 0; i < 400; i++) begin
         int op = $urandom % 6;
         step("R2 mix", ($urandom % 5) != 0, op == 1, op == 2, op == 3,
              $urandom, $urandom, ($urandom % 4) == 0, $urandom);
      end
      chk("R10 single-hot stimulus", multi_hot, 2);
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule